// File: doc/BRIEF.md
# Four-Bit Synchronous Up/Down Counter with Twin Count Strobes

This block is a four-bit counter clocked entirely from one system clock. A parameter builds it either as a plain binary counter that wraps after 15 or as a decimal digit that wraps after 9. Counting is requested through two separate strobes, one for each direction. There is no direction select. A synchronous clear and a parallel preset complete the controls. Every register updates on the same clock edge, so any state decoded from the count is free of glitches.

Two combinational terminal outputs mark the cycle in which the counter is about to roll over. The carry flag marks a rollover upward and the borrow flag a rollover downward. Wiring the carry of one stage to the up strobe of the next, and the borrow to the down strobe, chains digits into a wider counter that stays fully synchronous.

A bounce mode reuses the up strobe as a step request. In this mode a stored direction bit picks which way each step goes. When the count reaches an end state, the direction turns round, so the count sweeps back and forth between zero and the top value instead of wrapping.

Top module: `updown_ctr`

## Requirements
- R1: After reset the count is 0, the direction bit `dir_q` is 1 (upward) and, with idle inputs, both terminal flags are low.
- R2: `clr` high forces the count to 0 and `dir_q` to 1 at the next edge. It overrides `ld`, both strobes and bounce mode.
- R3: With `clr` low and `ld` high, the next edge copies `ld_val` into the count regardless of the strobes. Any four-bit value is accepted, including 10 to 15 in decimal mode.
- R4: In normal mode (`bounce_en` low), `up_req` alone advances a count below the top value by one at the next edge.
- R5: In normal mode, `dn_req` alone lowers a nonzero count by one at the next edge.
- R6: In normal mode, `up_req` and `dn_req` high together leave the count unchanged and keep both terminal flags low.
- R7: Counting up from the top value (15 binary, 9 decimal) gives 0. Counting down from 0 gives the top value.
- R8: `carry_o` is high, in the same cycle, exactly when the count equals the top value and `up_req` is high alone in normal mode.
- R9: `borrow_o` is high, in the same cycle, exactly when the count is 0 and `dn_req` is high alone in normal mode.
- R10: In decimal mode, an up count from a loaded value of 10 to 15 gives 0 without raising `carry_o`. A down count from such a value lowers it by one.
- R11: In bounce mode, `up_req` is a step request that moves the count one place in the direction held in `dir_q` (1 up, 0 down). A step taken at the end state of that direction (top value going up, 0 going down) inverts `dir_q` and instead moves the count one place the other way.
- R12: In bounce mode, `dn_req` has no effect and both terminal flags stay low. Outside bounce mode, `dir_q` changes only through `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of count and direction |
| ld | input | 1 | Parallel preset enable |
| ld_val | input | 4 | Preset value |
| up_req | input | 1 | Count-up strobe; step request in bounce mode |
| dn_req | input | 1 | Count-down strobe |
| bounce_en | input | 1 | Selects the self-reversing bounce mode |
| cnt_q | output | 4 | Registered count |
| dir_q | output | 1 | Registered bounce direction, 1 = upward |
| carry_o | output | 1 | Upward rollover flag for cascading |
| borrow_o | output | 1 | Downward rollover flag for cascading |

## Verification
A binary instance and a decimal instance receive identical stimulus, so each pattern shows how the two top values differ. Runs of single up strobes and single down strobes taken across the wrap points show whether the rollover and the terminal flags agree. Cycles with both strobes high, and cycles where clear, load and a strobe coincide, show whether the hold rule and the priority order are kept. Presets above 9 separate the decimal wrap from the binary increment. Long bounce-mode runs with the down strobe toggled throughout show whether the turn-round happens at both ends and whether the ignored strobe is truly ignored. A pseudo-random tail then mixes all the controls.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef struct packed {
    logic inc;
    logic dec;
  } step_s;

  // Largest count value of the selected variant.
  function automatic int top_value(input bit decimal, input int width);
    return decimal ? 9 : ((1 << width) - 1);
  endfunction

endpackage

// File: rtl/udc_rst_sync.sv
module udc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nx;

  always_comb begin
    sync_nx = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nx;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/udc_term.sv
module udc_term #(
  parameter int               WIDTH   = 4,
  parameter bit               DECIMAL = 1'b0,
  parameter logic [WIDTH-1:0] TOPV    = '1
) (
  input  logic [WIDTH-1:0] cnt,
  output logic             at_top,
  output logic             at_bot
);

  generate
    if (DECIMAL) begin : g_dec
      assign at_top = (cnt == TOPV);
    end else begin : g_bin
      assign at_top = &cnt;
    end
  endgenerate

  assign at_bot = ~|cnt;

endmodule

// File: rtl/udc_dir.sv
module udc_dir (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic          up_req,
  input  logic          dn_req,
  input  logic          bounce_en,
  input  logic          at_top,
  input  logic          at_bot,
  output udc_pkg::step_s step,
  output udc_pkg::dir_e  dir_q
);
  import udc_pkg::*;

  logic go_up;
  logic turn;
  logic dir_en;
  dir_e dir_nx;

  // Direction actually taken on a bounce step.
  always_comb begin
    if (dir_q == DIR_UP) go_up = ~at_top;
    else                 go_up = at_bot;
  end

  always_comb begin
    if (bounce_en) begin
      step.inc = up_req & go_up;
      step.dec = up_req & ~go_up;
    end else begin
      step.inc = up_req & ~dn_req;
      step.dec = dn_req & ~up_req;
    end
  end

  assign turn = bounce_en & up_req &
                (((dir_q == DIR_UP) & at_top) | ((dir_q == DIR_DOWN) & at_bot));

  always_comb begin
    dir_en = 1'b0;
    dir_nx = dir_q;
    if (clr) begin
      dir_en = 1'b1;
      dir_nx = DIR_UP;
    end else if (!ld && turn) begin
      dir_en = 1'b1;
      dir_nx = (dir_q == DIR_UP) ? DIR_DOWN : DIR_UP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_UP;
    end else if (dir_en) begin
      dir_q <= dir_nx;
    end
  end

  // R11: a step at the upper end turns the direction downward
  a_r11_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && bounce_en && up_req && dir_q == DIR_UP && at_top) |=> dir_q == DIR_DOWN);

  // R11: a step at zero turns the direction upward
  a_r11_turn_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && bounce_en && up_req && dir_q == DIR_DOWN && at_bot) |=> dir_q == DIR_UP);

  // R12: outside bounce mode only a clear moves the direction
  a_r12_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!bounce_en && !clr) |=> $stable(dir_q));

  // R2: clear restores upward direction
  a_r2_dir_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> dir_q == DIR_UP);

endmodule

// File: rtl/udc_core.sv
module udc_core #(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] TOPV  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  udc_pkg::step_s   step,
  output logic [WIDTH-1:0] cnt_q
);

  logic             cnt_en;
  logic [WIDTH-1:0] cnt_nx;

  // Priority: clear, then load, then one count step.
  always_comb begin
    cnt_en = 1'b0;
    cnt_nx = cnt_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_nx = '0;
    end else if (ld) begin
      cnt_en = 1'b1;
      cnt_nx = ld_val;
    end else if (step.inc) begin
      cnt_en = 1'b1;
      cnt_nx = (cnt_q >= TOPV) ? '0 : cnt_q + 1'b1;
    end else if (step.dec) begin
      cnt_en = 1'b1;
      cnt_nx = (cnt_q == '0) ? TOPV : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nx;
    end
  end

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

  a_r3_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ld) |=> cnt_q == $past(ld_val));

  a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && step.inc && cnt_q < TOPV) |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && step.dec && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r10_over_range_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && step.inc && cnt_q > TOPV) |=> cnt_q == '0);

endmodule

// File: rtl/updown_ctr.sv
module updown_ctr #(
  parameter int WIDTH   = 4,
  parameter bit DECIMAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             up_req,
  input  logic             dn_req,
  input  logic             bounce_en,
  output logic [WIDTH-1:0] cnt_q,
  output logic             dir_q,
  output logic             carry_o,
  output logic             borrow_o
);
  import udc_pkg::*;

  localparam logic [WIDTH-1:0] TOPV = WIDTH'(top_value(DECIMAL, WIDTH));

  logic  rst_n_int;
  logic  at_top;
  logic  at_bot;
  step_s step;
  dir_e  dir_st;

  udc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  udc_term #(.WIDTH(WIDTH), .DECIMAL(DECIMAL), .TOPV(TOPV)) u_term (
    .cnt    (cnt_q),
    .at_top (at_top),
    .at_bot (at_bot)
  );

  udc_dir u_dir (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (clr),
    .ld        (ld),
    .up_req    (up_req),
    .dn_req    (dn_req),
    .bounce_en (bounce_en),
    .at_top    (at_top),
    .at_bot    (at_bot),
    .step      (step),
    .dir_q     (dir_st)
  );

  udc_core #(.WIDTH(WIDTH), .TOPV(TOPV)) u_core (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr    (clr),
    .ld     (ld),
    .ld_val (ld_val),
    .step   (step),
    .cnt_q  (cnt_q)
  );

  assign dir_q    = dir_st;
  assign carry_o  = step.inc & at_top;
  assign borrow_o = step.dec & at_bot;

  // R8: carry announces a wrap to zero
  a_r8_carry_wraps: assert property (@(posedge clk) disable iff (!rst_n_int)
    (carry_o && !clr && !ld) |=> cnt_q == '0);

  // R9: borrow announces a wrap to the top value
  a_r9_borrow_wraps: assert property (@(posedge clk) disable iff (!rst_n_int)
    (borrow_o && !clr && !ld) |=> cnt_q == TOPV);

  // R6: both strobes together hold the count
  a_r6_both_hold: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!clr && !ld && !bounce_en && up_req && dn_req) |=> cnt_q == $past(cnt_q));

  // R12: terminal flags silent in bounce mode
  a_r12_bounce_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    bounce_en |-> (!carry_o && !borrow_o));

  // R8 and R9 never fire together
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(carry_o && borrow_o));

endmodule

// File: tb/sim_updown_ctr.sv
module sim_updown_ctr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, ld = 1'b0, up_req = 1'b0, dn_req = 1'b0, bounce_en = 1'b0;
  logic [3:0] ld_val = 4'd0;
  logic [3:0] cnt0, cnt1;
  logic       dir0, dir1, cy0, cy1, bw0, bw1;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updown_ctr #(.WIDTH(4), .DECIMAL(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .ld_val(ld_val),
    .up_req(up_req), .dn_req(dn_req), .bounce_en(bounce_en),
    .cnt_q(cnt0), .dir_q(dir0), .carry_o(cy0), .borrow_o(bw0));

  updown_ctr #(.WIDTH(4), .DECIMAL(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .ld_val(ld_val),
    .up_req(up_req), .dn_req(dn_req), .bounce_en(bounce_en),
    .cnt_q(cnt1), .dir_q(dir1), .carry_o(cy1), .borrow_o(bw1));

  typedef struct {
    string tag;
    int    cnt [2];
    bit    dir [2];
    bit    cy  [2];
    bit    bw  [2];
  } exp_t;

  exp_t sb[$];

  // Reference state of each instance (0 binary, 1 decimal).
  int m_cnt [2];
  bit m_dir [2];
  int m_top [2] = '{15, 9};

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs, queue expected values, advance model.
  task automatic step(input string tag, input bit c, input bit l, input int v,
                      input bit u, input bit d, input bit b);
    exp_t e;
    @(posedge clk);
    #2;
    clr = c; ld = l; ld_val = 4'(v); up_req = u; dn_req = d; bounce_en = b;
    e.tag = tag;
    for (int k = 0; k < 2; k++) begin
      bit inc, dec, go;
      int mx;
      mx = m_top[k];
      if (b) begin
        go  = m_dir[k] ? (m_cnt[k] != mx) : (m_cnt[k] == 0);
        inc = u & go;
        dec = u & ~go;
      end else begin
        inc = u & ~d;
        dec = d & ~u;
      end
      e.cnt[k] = m_cnt[k];
      e.dir[k] = m_dir[k];
      e.cy[k]  = inc && (m_cnt[k] == mx);
      e.bw[k]  = dec && (m_cnt[k] == 0);
      if (c) begin
        m_cnt[k] = 0;
        m_dir[k] = 1'b1;
      end else if (l) begin
        m_cnt[k] = v & 15;
      end else begin
        if (b && u && ((m_dir[k] && m_cnt[k] == mx) || (!m_dir[k] && m_cnt[k] == 0)))
          m_dir[k] = ~m_dir[k];
        if (inc)      m_cnt[k] = (m_cnt[k] >= mx) ? 0 : m_cnt[k] + 1;
        else if (dec) m_cnt[k] = (m_cnt[k] == 0) ? mx : m_cnt[k] - 1;
      end
    end
    sb.push_back(e);
  endtask

  // Monitor: mid-cycle, compare outputs against the oldest queued item.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "bin count",  int'(cnt0), e.cnt[0]);
        check(e.tag, "bin dir",    int'(dir0), int'(e.dir[0]));
        check(e.tag, "bin carry",  int'(cy0),  int'(e.cy[0]));
        check(e.tag, "bin borrow", int'(bw0),  int'(e.bw[0]));
        check(e.tag, "dec count",  int'(cnt1), e.cnt[1]);
        check(e.tag, "dec dir",    int'(dir1), int'(e.dir[1]));
        check(e.tag, "dec carry",  int'(cy1),  int'(e.cy[1]));
        check(e.tag, "dec borrow", int'(bw1),  int'(e.bw[1]));
      end
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_cnt[k] = 0;
      m_dir[k] = 1'b1;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state with idle inputs
    step("R1", 0, 0, 0, 0, 0, 0);
    // R4: plain up counting
    repeat (4) step("R4", 0, 0, 0, 1, 0, 0);
    // R5: plain down counting
    repeat (2) step("R5", 0, 0, 0, 0, 1, 0);
    // R6: both strobes hold
    repeat (2) step("R6", 0, 0, 0, 1, 1, 0);
    // R3: load wins over a strobe
    step("R3", 0, 1, 7, 1, 0, 0);
    repeat (3) step("R4", 0, 0, 0, 1, 0, 0);
    // R7 and R8: reach the top and wrap with carry
    step("R3", 0, 1, 14, 0, 0, 0);
    repeat (3) step("R8", 0, 0, 0, 1, 0, 0);
    step("R3", 0, 1, 9, 0, 1, 0);
    repeat (2) step("R7", 0, 0, 0, 1, 0, 0);
    // R9 and R7: borrow from zero
    step("R2", 1, 1, 5, 1, 0, 0);
    repeat (3) step("R9", 0, 0, 0, 0, 1, 0);
    // R2: clear beats load and strobes, in both modes
    step("R2", 1, 1, 11, 1, 1, 1);
    step("R2", 0, 0, 0, 0, 0, 0);
    // R10: decimal over-range values
    step("R10", 0, 1, 12, 0, 0, 0);
    repeat (2) step("R10", 0, 0, 0, 1, 0, 0);
    step("R10", 0, 1, 15, 0, 0, 0);
    repeat (2) step("R10", 0, 0, 0, 0, 1, 0);
    step("R10", 0, 1, 10, 1, 0, 0);
    step("R10", 0, 0, 0, 1, 0, 0);
    // R11 and R12: bounce mode, down strobe toggling and ignored
    step("R3", 0, 1, 6, 0, 0, 0);
    for (int i = 0; i < 40; i++) step("R11", 0, 0, 0, 1, i[0], 1);
    repeat (3) step("R12", 0, 0, 0, 0, 1, 1);
    // R12: direction frozen once bounce mode ends
    repeat (3) step("R12", 0, 0, 0, 0, 1, 0);
    repeat (3) step("R12", 0, 0, 0, 1, 0, 0);
    // R11: load during bounce does not turn, clear restores upward
    step("R11", 0, 1, 0, 1, 0, 1);
    repeat (3) step("R11", 0, 0, 0, 1, 0, 1);
    step("R2", 1, 0, 0, 1, 0, 1);
    repeat (2) step("R11", 0, 0, 0, 1, 0, 1);
    // Mixed pseudo-random tail
    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step("R4", (lfsr[7:3] == 5'd0), (lfsr[6:2] == 5'd3), int'(lfsr[11:8]),
             lfsr[0], lfsr[1], (i >= 200));
      end
    end
    step("R4", 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule